// File: doc/BRIEF.md
# Bus Clock Start-Up Sequencer

This block sits between a fast oscillator and the bus-clocked part of a small controller. It does not make new clocks. It produces two clock enables, one for the processor and one for the peripherals. Each is high for one oscillator cycle out of every four, so the bus runs at a quarter of the oscillator rate. The block also decides when those enables may run at all.

After power-on the enables stay off while a shared start-up counter counts a fixed number of oscillator cycles. During that time an active-low reset output is held low. A stop request parks the whole bus. A later wake event starts the same counter on a recovery delay, which is long or short as chosen by a select bit captured at stop entry. A wait request silences only the processor enable and leaves the peripheral enable running.

The power-on input is asynchronous. It is released into the logic through a two-stage synchronizer.

Top module: `bus_clk_startup_seq`

## Requirements
- R1: While `por_n` is low, and for 4096 oscillator cycles of counting after its synchronized release, `rst_pin_n`, `cpu_clk_en` and `per_clk_en` are all 0. Lowering `por_n` forces all three to 0 at once, without waiting for a clock edge.
- R2: `rst_pin_n` first reads 1 after the 4098th rising edge that follows the release of `por_n`: 2 synchronizer edges plus 4096 counted edges. The first `per_clk_en` pulse follows exactly 3 cycles later, because the divider phase restarts from zero at every time-out.
- R3: In normal running, `per_clk_en` and `cpu_clk_en` are equal. Each is high for one cycle and then low for three cycles.
- R4: A `stop_req` that is high on a boundary cycle (a cycle in which `per_clk_en` is high) enters stop. From the next cycle on, both enables stay 0 until the block leaves stop.
- R5: In stop, a one-cycle `wake_evt` starts recovery. The enables stay 0 for the recovery delay, and the first `per_clk_en` is seen 36 cycles after the cycle in which wake was raised for the short delay, or 4100 cycles for the long delay. The short delay is 32 counted cycles and the long delay is 4096.
- R6: The delay is chosen by `short_dly_sel` as sampled at stop entry (1 = short, 0 = long). Changing it during stop or recovery has no effect.
- R7: A `wait_req` on a boundary cycle, with `stop_req` low, turns `cpu_clk_en` off. `per_clk_en` keeps its one-in-four rhythm without a break.
- R8: In wait, a `wake_evt` that is high on a boundary cycle returns the block to running. `cpu_clk_en` is high again 4 cycles later, with no counted delay.
- R9: When `stop_req` and `wait_req` are both high on a boundary cycle, stop wins and both enables stop.
- R10: `rst_pin_n` is 1 throughout stop and recovery. Only the power-on period drives it low.
- R11: The following are ignored:
  - `stop_req` and `wait_req` during power-on counting and during recovery;
  - `wake_evt` while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; every register runs on it |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_req | input | 1 | Request to enter stop, taken on a boundary cycle |
| wait_req | input | 1 | Request to enter wait, taken on a boundary cycle |
| wake_evt | input | 1 | Interrupt, break or reset wake event |
| short_dly_sel | input | 1 | 1 selects the short stop-recovery delay, sampled at stop entry |
| cpu_clk_en | output | 1 | Processor bus-clock enable |
| per_clk_en | output | 1 | Peripheral bus-clock enable |
| rst_pin_n | output | 1 | Active-low external reset drive |

## Verification
The hardest state to reach from the ports is a stop recovery on the long delay in which the select bit has been changed in the meantime. Also hard to reach is a recovery during which stop and wait requests arrive and must not take effect. The bench reaches both by waiting for a cycle in which `per_clk_en` is high, and only then raising a request, so that entry falls on a known boundary. While the block is parked, it flips `short_dly_sel` and pulses the requests. It then counts the cycles from the wake to the first enable. A behavioural cycle model built on integers is compared with all three outputs on every cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    SEQ_POR   = 3'd0,
    SEQ_RUN   = 3'd1,
    SEQ_WAIT  = 3'd2,
    SEQ_STOP  = 3'd3,
    SEQ_RECOV = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcs_delay_cnt.sv
module bcs_delay_cnt #(
  parameter int unsigned POR_CYCLES   = 4096,
  parameter int unsigned LONG_CYCLES  = 4096,
  parameter int unsigned SHORT_CYCLES = 32,
  parameter int unsigned CW           = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  input  logic pick_por,
  input  logic pick_short,
  output logic done
);
  localparam logic [CW-1:0] POR_LAST   = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] tgt_last;

  always_comb begin
    if (pick_por)        tgt_last = POR_LAST;
    else if (pick_short) tgt_last = SHORT_LAST;
    else                 tgt_last = LONG_LAST;
  end

  assign done = inc && (cnt_q == tgt_last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (inc)  cnt_d = done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the count never passes the selected time-out
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (cnt_q <= tgt_last));
  // R1: a cleared counter restarts from zero
  assert_cnt_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/bcs_phase_div.sv
module bcs_phase_div #(
  parameter int unsigned DIV_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic boundary
);
  localparam int unsigned PW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV_RATIO - 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;

  assign boundary = run && (ph_q == PH_LAST);

  always_comb begin
    if (!run)          ph_d = '0;
    else if (boundary) ph_d = '0;
    else               ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R3: the phase wraps to zero after each boundary
  assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (ph_q == '0));
  // R2: a stopped divider sits at phase zero
  assert_phase_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ph_q == '0));
endmodule

// File: rtl/bcs_ctrl_fsm.sv
module bcs_ctrl_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake_evt,
  input  logic       short_sel,
  input  logic       boundary,
  input  logic       cnt_done,
  output seq_state_e state,
  output logic       cnt_inc,
  output logic       cnt_clr,
  output logic       pick_por,
  output logic       pick_short,
  output logic       ph_run
);
  seq_state_e st_q;
  seq_state_e st_d;
  logic       sel_q;
  logic       sel_load;

  always_comb begin
    st_d     = st_q;
    sel_load = 1'b0;
    unique case (st_q)
      SEQ_POR:   if (cnt_done) st_d = SEQ_RUN;
      SEQ_RUN: begin
        if (boundary && stop_req) begin
          st_d     = SEQ_STOP;
          sel_load = 1'b1;
        end else if (boundary && wait_req) begin
          st_d = SEQ_WAIT;
        end
      end
      SEQ_WAIT:  if (boundary && wake_evt) st_d = SEQ_RUN;
      SEQ_STOP:  if (wake_evt) st_d = SEQ_RECOV;
      SEQ_RECOV: if (cnt_done) st_d = SEQ_RUN;
      default:   st_d = SEQ_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_POR;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 1'b0;
    else if (sel_load) sel_q <= short_sel;
  end

  assign state      = st_q;
  assign cnt_inc    = (st_q == SEQ_POR) || (st_q == SEQ_RECOV);
  assign cnt_clr    = !cnt_inc;
  assign pick_por   = (st_q == SEQ_POR);
  assign pick_short = sel_q;
  assign ph_run     = (st_q == SEQ_RUN) || (st_q == SEQ_WAIT);

  // R4: a boundary stop request enters stop
  assert_stop_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && boundary && stop_req) |=> (st_q == SEQ_STOP));
  // R6: the captured delay choice holds while parked or recovering
  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_STOP || st_q == SEQ_RECOV) |=> $stable(sel_q));
  // R11: recovery only ends through the counter
  assert_recov_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RECOV && !cnt_done) |=> (st_q == SEQ_RECOV));
  // R8: wait ends only on a boundary with a wake event
  assert_wait_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WAIT && !(boundary && wake_evt)) |=> (st_q == SEQ_WAIT));
endmodule

// File: rtl/bus_clk_startup_seq.sv
module bus_clk_startup_seq
  import bcs_pkg::*;
#(
  parameter int unsigned DIV_RATIO         = 4,
  parameter int unsigned POR_CYCLES        = 4096,
  parameter int unsigned LONG_STOP_CYCLES  = 4096,
  parameter int unsigned SHORT_STOP_CYCLES = 32,
  parameter int unsigned SYNC_STAGES       = 2
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic stop_req,
  input  logic wait_req,
  input  logic wake_evt,
  input  logic short_dly_sel,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic rst_pin_n
);
  localparam int unsigned MAX_CYCLES = max3(POR_CYCLES, LONG_STOP_CYCLES, SHORT_STOP_CYCLES);
  localparam int unsigned CNT_W      = $clog2(MAX_CYCLES + 1);

  logic       rst_n;
  seq_state_e state;
  logic       cnt_inc;
  logic       cnt_clr;
  logic       pick_por;
  logic       pick_short;
  logic       cnt_done;
  logic       ph_run;
  logic       boundary;

  bcs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (osc_clk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  bcs_delay_cnt #(
    .POR_CYCLES   (POR_CYCLES),
    .LONG_CYCLES  (LONG_STOP_CYCLES),
    .SHORT_CYCLES (SHORT_STOP_CYCLES),
    .CW           (CNT_W)
  ) u_cnt (
    .clk        (osc_clk),
    .rst_n      (rst_n),
    .inc        (cnt_inc),
    .clr        (cnt_clr),
    .pick_por   (pick_por),
    .pick_short (pick_short),
    .done       (cnt_done)
  );

  bcs_phase_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .run      (ph_run),
    .boundary (boundary)
  );

  bcs_ctrl_fsm u_fsm (
    .clk        (osc_clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .wait_req   (wait_req),
    .wake_evt   (wake_evt),
    .short_sel  (short_dly_sel),
    .boundary   (boundary),
    .cnt_done   (cnt_done),
    .state      (state),
    .cnt_inc    (cnt_inc),
    .cnt_clr    (cnt_clr),
    .pick_por   (pick_por),
    .pick_short (pick_short),
    .ph_run     (ph_run)
  );

  assign per_clk_en = boundary;
  assign cpu_clk_en = boundary && (state == SEQ_RUN);
  assign rst_pin_n  = (state != SEQ_POR);

  // R1: no bus enable while the reset output is low
  assert_quiet_in_por_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !rst_pin_n |-> (!per_clk_en && !cpu_clk_en));
  // R7: the processor enable is never on without the peripheral enable
  assert_cpu_in_per_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);
  // R3: an enable pulse lasts a single oscillator cycle
  assert_pulse_width_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    per_clk_en |=> !per_clk_en);
  // R10: stop never drives the reset output
  assert_rst_stop_R10: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (state == SEQ_STOP || state == SEQ_RECOV) |-> rst_pin_n);
endmodule

// File: tb/bus_clk_startup_seq_test.sv
`timescale 1ns/1ps
module bus_clk_startup_seq_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic stop_req = 1'b0;
  logic wait_req = 1'b0;
  logic wake_evt = 1'b0;
  logic short_dly_sel = 1'b0;
  logic cpu_clk_en, per_clk_en, rst_pin_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_clk_startup_seq uut (
    .osc_clk(clk), .por_n(por_n), .stop_req(stop_req), .wait_req(wait_req),
    .wake_evt(wake_evt), .short_dly_sel(short_dly_sel),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .rst_pin_n(rst_pin_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  localparam int M_POR = 0, M_RUN = 1, M_WAIT = 2, M_STOP = 3, M_REC = 4;
  int m_mode = M_POR;
  int m_cnt = 0;
  int m_ph = 0;
  int m_sel = 0;
  int m_s1 = 0;
  int m_s2 = 0;

  always @(negedge por_n) begin
    m_mode = M_POR; m_cnt = 0; m_ph = 0; m_sel = 0; m_s1 = 0; m_s2 = 0;
  end

  always @(posedge clk) begin
    if (!por_n) begin
      m_mode = M_POR; m_cnt = 0; m_ph = 0; m_sel = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (m_s2 == 1) begin
        bit bnd;
        int lim;
        bnd = (m_ph == 3);
        case (m_mode)
          M_POR: begin
            if (m_cnt == 4095) begin m_mode = M_RUN; m_cnt = 0; m_ph = 0; end
            else m_cnt++;
          end
          M_RUN: begin
            m_ph = (m_ph + 1) % 4;
            if (bnd && stop_req) begin m_mode = M_STOP; m_sel = short_dly_sel; m_ph = 0; end
            else if (bnd && wait_req) m_mode = M_WAIT;
          end
          M_WAIT: begin
            m_ph = (m_ph + 1) % 4;
            if (bnd && wake_evt) m_mode = M_RUN;
          end
          M_STOP: if (wake_evt) begin m_mode = M_REC; m_cnt = 0; end
          default: begin
            lim = (m_sel != 0) ? 32 : 4096;
            if (m_cnt == lim - 1) begin m_mode = M_RUN; m_cnt = 0; m_ph = 0; end
            else m_cnt++;
          end
        endcase
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  always @(negedge clk) begin
    int expv;
    string tag;
    expv = {(m_mode == M_RUN && m_ph == 3) ? 1 : 0} * 4 +
           {((m_mode == M_RUN || m_mode == M_WAIT) && m_ph == 3) ? 1 : 0} * 2 +
           ((m_mode != M_POR) ? 1 : 0);
    case (m_mode)
      M_POR:   tag = "R1 model";
      M_RUN:   tag = "R3 model";
      M_WAIT:  tag = "R7 model";
      M_STOP:  tag = "R4 model";
      default: tag = "R5 model";
    endcase
    chk(tag, {29'd0, cpu_clk_en, per_clk_en, rst_pin_n}, expv);
  end

  task automatic at_boundary();
    do @(negedge clk); while (!per_clk_en);
  endtask

  task automatic count_en(input int cycles, output int n_per, output int n_cpu);
    n_per = 0; n_cpu = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      n_per += per_clk_en;
      n_cpu += cpu_clk_en;
    end
  endtask

  task automatic wake_and_measure(input int pulse_at, output int n);
    wake_evt = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) wake_evt = 1'b0;
      if (n == pulse_at) begin stop_req = 1'b1; wait_req = 1'b1; end
      if (n == pulse_at + 1) begin stop_req = 1'b0; wait_req = 1'b0; end
    end while (!per_clk_en && n < 10000);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, np, nc;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset rst_pin_n", rst_pin_n, 0);
    chk("R1 reset enables", {30'd0, cpu_clk_en, per_clk_en}, 0);
    por_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_pin_n && n < 10000);
    chk("R2 reset release edges", n, 4098);
    n = 0;
    do begin @(negedge clk); n++; end while (!per_clk_en && n < 100);
    chk("R2 first enable gap", n, 3);
    count_en(16, np, nc);
    chk("R3 per pulses in 16", np, 4);
    chk("R3 cpu pulses in 16", nc, 4);
    // R11: wake in run has no effect
    at_boundary(); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    count_en(16, np, nc);
    chk("R11 wake in run cpu", nc, 4);
    // short stop, select flipped during stop
    short_dly_sel = 1'b1;
    at_boundary(); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; short_dly_sel = 1'b0;
    count_en(20, np, nc);
    chk("R4 stop per quiet", np, 0);
    chk("R4 stop cpu quiet", nc, 0);
    chk("R10 rst high in stop", rst_pin_n, 1);
    wake_and_measure(5, n);
    chk("R5 short delay with R6 change and R11 requests", n, 36);
    // long stop, select flipped to short during stop
    at_boundary(); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; short_dly_sel = 1'b1;
    repeat (5) @(negedge clk);
    wake_and_measure(100, n);
    chk("R5 long delay", n, 4100);
    chk("R6 select at entry kept", n, 4100);
    // wait
    at_boundary(); wait_req = 1'b1;
    @(negedge clk); wait_req = 1'b0;
    count_en(16, np, nc);
    chk("R7 wait per keeps running", np, 4);
    chk("R7 wait cpu off", nc, 0);
    at_boundary(); wake_evt = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) wake_evt = 1'b0;
    end while (!cpu_clk_en && n < 100);
    chk("R8 wait exit latency", n, 4);
    // both requests at once
    at_boundary(); stop_req = 1'b1; wait_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; wait_req = 1'b0;
    count_en(12, np, nc);
    chk("R9 stop over wait", np, 0);
    wake_and_measure(1000, n);
    chk("R9 recovery after stop", n, 36);
    // asynchronous reset
    @(negedge clk); #1 por_n = 1'b0;
    #0.5;
    chk("R1 async rst_pin_n", rst_pin_n, 0);
    chk("R1 async enables", {30'd0, cpu_clk_en, per_clk_en}, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule